// File: doc/BRIEF.md
# VGA Sync Timing Generator

This block produces the raster timing for a simple VGA display from one pixel clock, nominally 25 MHz. Two free-running counters hold the current pixel column and line. The column counter runs over a fixed line length. Each time it wraps, the line counter advances. Drawing logic downstream reads both positions from the ports to choose a colour for each pixel.

The two sync outputs are active-low and are taken from flip-flops, so decode glitches never reach the pins. The horizontal pulse comes from a coarse compare on the upper bits of the column counter. The vertical pulse is decoded from line zero. Both pulses sit at the start of their counter range and there are no separate porch intervals. The timing is therefore only close to the usual rates of about 31.5 kHz per line and 60 Hz per frame. An active-video flag marks the visible window so that colour logic can blank every other pixel.

Top module: `vga_sync_gen`

## Requirements
- R1: `pos_x` increases by one on every clock from 0 up to H_TOTAL-1 (default 767), then returns to 0 on the next clock.
- R2: `pos_y` advances by one only on the clock where `pos_x` wraps from H_TOTAL-1 to 0. It returns to 0 after V_TOTAL-1 (default 524) and otherwise holds its value.
- R3: `hsync_n` is low on exactly the clock cycles that follow a cycle in which bits 9..4 of `pos_x` were all zero (`pos_x` below H_SYNC_LEN = 16). This gives a low pulse 16 cycles wide.
- R4: Successive falling edges of `hsync_n` are exactly H_TOTAL (768) cycles apart.
- R5: `vsync_n` is low on exactly the clock cycles that follow a cycle in which `pos_y` was 0. This gives a low pulse of one full line (768 cycles).
- R6: Successive falling edges of `vsync_n` are exactly H_TOTAL × V_TOTAL cycles apart (768 × 525 at defaults).
- R7: While the synchronous active-high `rst` is sampled high, both counters are set to 0 and both sync outputs are set high. Counting resumes from 0 after `rst` is released, including when reset is applied in the middle of a frame.
- R8: `active` is 1 exactly when `pos_x` < H_ACTIVE (640) and `pos_y` < V_ACTIVE (480), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, nominally 25 MHz |
| rst | input | 1 | Synchronous active-high reset |
| pos_x | output | X_W (10) | Current pixel column |
| pos_y | output | Y_W (10) | Current line |
| active | output | 1 | High inside the visible window |
| hsync_n | output | 1 | Registered horizontal sync, active-low |
| vsync_n | output | 1 | Registered vertical sync, active-low |

## Verification
A behavioural model with integer counters predicts every output, and the bench compares it with the design on every clock. This covers free-running lines, the wrap of the line counter at the end of a frame, and the edges of the visible window, where an off-by-one error in a compare shows up as a mismatch on `active`. Separate edge-timing monitors measure the low-pulse widths and the falling-edge periods of both syncs. These tell a wrong bit-slice or a missing register stage apart from a wrong wrap point. A reset asserted in the middle of a frame checks that both counters restart from zero and that both syncs return high. The line count is made shorter in the bench so that whole frames fit in the run. The line length and the pulse widths keep their default values.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;
  // Default raster geometry shared across the design
  localparam int DEF_H_TOTAL  = 768;
  localparam int DEF_V_TOTAL  = 525;
  localparam int DEF_H_ACTIVE = 640;
  localparam int DEF_V_ACTIVE = 480;
  localparam int DEF_H_SYNC   = 16;

  typedef struct packed {
    logic hs;
    logic vs;
  } sync_pair_t;
endpackage

// File: rtl/vga_line_counter.sv
module vga_line_counter #(
  parameter int H_TOTAL = 768,
  parameter int X_W     = $clog2(H_TOTAL)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [X_W-1:0] cx,
  output logic           line_end
);
  localparam logic [X_W-1:0] X_LAST = X_W'(H_TOTAL - 1);

  assign line_end = (cx == X_LAST);

  always_ff @(posedge clk) begin
    if (rst)           cx <= '0;
    else if (line_end) cx <= '0;
    else               cx <= cx + 1'b1;
  end

  // R1: wrap after the last column
  assert_x_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (cx == X_LAST) |=> (cx == '0));
  // R1: step by one elsewhere
  assert_x_step_R1: assert property (@(posedge clk) disable iff (rst)
    (cx != X_LAST) |=> (cx == $past(cx) + 1'b1));
endmodule

// File: rtl/vga_frame_counter.sv
module vga_frame_counter #(
  parameter int V_TOTAL = 525,
  parameter int Y_W     = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           advance,
  output logic [Y_W-1:0] cy
);
  localparam logic [Y_W-1:0] Y_LAST = Y_W'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst)            cy <= '0;
    else if (advance) begin
      if (cy == Y_LAST) cy <= '0;
      else              cy <= cy + 1'b1;
    end
  end

  // R2: line count holds between line ends
  assert_y_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(cy));
  // R2: wrap at the last line
  assert_y_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && cy == Y_LAST) |=> (cy == '0));
endmodule

// File: rtl/vga_sync_decode.sv
module vga_sync_decode
  import vga_sync_pkg::*;
#(
  parameter int H_ACTIVE   = 640,
  parameter int V_ACTIVE   = 480,
  parameter int H_SYNC_LEN = 16,
  parameter int X_W        = 10,
  parameter int Y_W        = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [X_W-1:0] cx,
  input  logic [Y_W-1:0] cy,
  output sync_pair_t     sync_q,
  output logic           active
);
  localparam int HS_SHIFT = $clog2(H_SYNC_LEN);
  localparam logic [X_W-1:0] X_VIS = X_W'(H_ACTIVE);
  localparam logic [Y_W-1:0] Y_VIS = Y_W'(V_ACTIVE);

  sync_pair_t sync_d;

  always_comb begin
    sync_d.hs = (cx[X_W-1:HS_SHIFT] == '0);
    sync_d.vs = (cy == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= sync_d;
  end

  assign active = (cx < X_VIS) && (cy < Y_VIS);
endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
  import vga_sync_pkg::*;
#(
  parameter int H_TOTAL    = DEF_H_TOTAL,
  parameter int V_TOTAL    = DEF_V_TOTAL,
  parameter int H_ACTIVE   = DEF_H_ACTIVE,
  parameter int V_ACTIVE   = DEF_V_ACTIVE,
  parameter int H_SYNC_LEN = DEF_H_SYNC,
  parameter int X_W        = $clog2(H_TOTAL),
  parameter int Y_W        = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [X_W-1:0] pos_x,
  output logic [Y_W-1:0] pos_y,
  output logic           active,
  output logic           hsync_n,
  output logic           vsync_n
);
  logic       line_end;
  sync_pair_t sync_q;

  vga_line_counter #(.H_TOTAL(H_TOTAL), .X_W(X_W)) u_line (
    .clk(clk), .rst(rst), .cx(pos_x), .line_end(line_end));

  vga_frame_counter #(.V_TOTAL(V_TOTAL), .Y_W(Y_W)) u_frame (
    .clk(clk), .rst(rst), .advance(line_end), .cy(pos_y));

  vga_sync_decode #(.H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .H_SYNC_LEN(H_SYNC_LEN), .X_W(X_W), .Y_W(Y_W)) u_dec (
    .clk(clk), .rst(rst), .cx(pos_x), .cy(pos_y),
    .sync_q(sync_q), .active(active));

  assign hsync_n = ~sync_q.hs;
  assign vsync_n = ~sync_q.vs;

  // R3: last low cycle of the horizontal pulse
  assert_hs_low_R3: assert property (@(posedge clk) disable iff (rst)
    (pos_x == X_W'(H_SYNC_LEN)) |-> !hsync_n);
  // R3: pulse has ended one column later
  assert_hs_end_R3: assert property (@(posedge clk) disable iff (rst)
    (pos_x == X_W'(H_SYNC_LEN + 1)) |-> hsync_n);
  // R5: vertical pulse spans the line after line zero
  assert_vs_low_R5: assert property (@(posedge clk) disable iff (rst)
    (pos_y == '0 && pos_x == X_W'(1) && $past(pos_y) == '0) |-> !vsync_n);
  // R5: vertical pulse released on line one
  assert_vs_end_R5: assert property (@(posedge clk) disable iff (rst)
    (pos_y == Y_W'(1) && pos_x == X_W'(1)) |-> vsync_n);
  // R7: reset drives syncs high
  assert_rst_idle_R7: assert property (@(posedge clk)
    rst |=> (hsync_n && vsync_n && pos_x == '0 && pos_y == '0));
endmodule

// File: tb/sim_vga_sync_gen.sv
module sim_vga_sync_gen;
  localparam int HT = 768, VT = 20, HA = 640, VA = 12, HSL = 16;

  logic clk = 0, rst = 1;
  logic [9:0] pos_x;
  logic [4:0] pos_y;
  logic active, hsync_n, vsync_n;

  always #5 clk = ~clk;

  vga_sync_gen #(.H_TOTAL(HT), .V_TOTAL(VT), .H_ACTIVE(HA), .V_ACTIVE(VA),
    .H_SYNC_LEN(HSL)) u0 (
    .clk(clk), .rst(rst), .pos_x(pos_x), .pos_y(pos_y), .active(active),
    .hsync_n(hsync_n), .vsync_n(vsync_n));

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int mx = 0, my = 0;
  bit mhs = 0, mvs = 0;
  always @(posedge clk) begin
    if (rst) begin
      mx = 0; my = 0; mhs = 0; mvs = 0;
    end else begin
      mhs = (mx < HSL);
      mvs = (my == 0);
      if (mx == HT - 1) begin
        mx = 0;
        my = (my == VT - 1) ? 0 : my + 1;
      end else mx = mx + 1;
    end
  end

  // per-cycle compare and edge timing
  longint cyc = 0;
  longint h_fall = -1, v_fall = -1;
  bit prev_h = 1, prev_v = 1;
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk(int'(pos_x) == mx, "R1 pos_x", pos_x, mx);
      chk(int'(pos_y) == my, "R2 pos_y", pos_y, my);
      chk(hsync_n == !mhs, "R3 hsync_n", hsync_n, !mhs);
      chk(vsync_n == !mvs, "R5 vsync_n", vsync_n, !mvs);
      chk(active == (mx < HA && my < VA), "R8 active", active, (mx < HA && my < VA));
      if (prev_h && !hsync_n) begin
        if (h_fall >= 0) chk(cyc - h_fall == HT, "R4 hsync period", cyc - h_fall, HT);
        h_fall = cyc;
      end
      if (!prev_h && hsync_n && h_fall >= 0)
        chk(cyc - h_fall == HSL, "R3 hsync width", cyc - h_fall, HSL);
      if (prev_v && !vsync_n) begin
        if (v_fall >= 0) chk(cyc - v_fall == HT * VT, "R6 vsync period", cyc - v_fall, HT * VT);
        v_fall = cyc;
      end
      if (!prev_v && vsync_n && v_fall >= 0)
        chk(cyc - v_fall == HT, "R5 vsync width", cyc - v_fall, HT);
    end
    if (rst) begin
      h_fall = -1; v_fall = -1;
    end
    prev_h = hsync_n; prev_v = vsync_n;
  end

  task automatic check_reset_state();
    chk(pos_x == 0, "R7 pos_x reset", pos_x, 0);
    chk(pos_y == 0, "R7 pos_y reset", pos_y, 0);
    chk(hsync_n == 1, "R7 hsync_n reset", hsync_n, 1);
    chk(vsync_n == 1, "R7 vsync_n reset", vsync_n, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state();
    rst = 0;
    repeat (HT * VT * 2 + HT * 3 + 100) @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 0;
    repeat (HT * VT + HT * 2 + 50) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule